// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the device side of a four-wire SPI link that fronts a 512 x 8 byte store held in ordinary registers. A host lowers chip select, shifts an instruction byte into SI, and then sends address and data bytes or shifts result bytes out of SO. The block decodes six instructions: set and clear a write-enable latch, read and write a status register, read a run of bytes, and write a page of up to four bytes. The SPI pins are oversampled by the system clock, so SCK must run several times slower than `clk_i`.

A page write is gathered in a small buffer. It is committed in one self-timed programming pass of `PROG_CYCLES` clock cycles once chip select rises. A busy bit in the status register reports that pass to the host. Writes are refused unless the write-enable latch is set. Further gates are a two-bit region code in the status register and a write-protect pin. A hold input freezes the transfer mid-stream and releases SO.

Top module: `spi_eep_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, every byte of the array reads 0x00, and SO is not driven while chip select is high.
- R2: SO is not driven (so_en_o low) while cs_ni is high or hold_ni is low, and so_o is 0 after chip select has been high for a full cycle.
- R3: Instruction 0x06 sets the write-enable latch and 0x04 clears it. Instruction 0x05 returns the status byte {4'b0, bp[1:0], wel, busy}: busy is bit 0, the latch is bit 1, and the region code is bits 3:2.
- R4: The read instruction is 0x03 with address bit 8 in opcode bit 3, followed by address bits 7:0. SI is sampled on rising SCK and SO changes on falling SCK, MSB first. Data continues from successive addresses for as long as chip select stays low, wrapping from 0x1FF to 0x000.
- R5: The write instruction is 0x02 with address bit 8 in opcode bit 3, followed by the address and data bytes. Successive data bytes advance only the low two address bits, which wrap within the four-byte page, so a later byte overwrites an earlier one at the same slot.
- R6: Programming starts only when chip select rises after a whole number of data bytes, with at least one byte received. A rise in the middle of a byte abandons the write and leaves the latch set.
- R7: While programming, busy reads 1 for PROG_CYCLES clock cycles. When it ends, the array holds the new bytes and the write-enable latch is 0.
- R8: While busy, only the status read is answered. Any other instruction, including a status write or a read, is ignored.
- R9: A write or status write sent with the write-enable latch clear changes nothing.
- R10: The region code blocks array writes to these address ranges: 01 blocks 0x180-0x1FF, 10 blocks 0x100-0x1FF, and 11 blocks the whole array.
- R11: With wp_ni low, neither the array nor the region code can be written.
- R12: While hold_ni is low, SCK edges are ignored. The transfer continues unchanged once hold_ni returns high.
- R13: Instruction 0x01 followed by a data byte loads the region code from data bits 3:2 and clears the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause transfer, active low |
| wp_ni | input | 1 | Write protect, active low |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output enable for SO; low means high impedance |

## Verification
Random page writes vary the start address, including the top half of the array, and the byte count from one to six. Counts above four exercise the slot wrap and overwrite, so an error in the page index or in the commit mask shows up. Sequential reads over random ranges and over the 0x1FF boundary separate a correct address increment from one that stalls or runs past the top. Directed cases place each kind of refusal against a correctly accepted write on the same path: no latch, pin protection, each region code, a mid-byte abort, and commands sent while busy. A hold inserted mid-byte shows whether SCK edges leak through during the pause.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_A8_MASK = 8'hF7;  // opcode bit 3 carries address bit 8

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRDATA, ST_RDSR, ST_IGN
  } eep_st_e;

  function automatic logic region_locked(input logic [ADDR_W-1:0] a, input logic [1:0] bp);
    case (bp)
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spi_eep_frontend.sv
module spi_eep_frontend (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       si_i,
  input  logic       hold_ni,
  output logic       sck_rise_o,
  output logic       sck_fall_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic [2:0] bit_cnt_o,
  output logic       cs_rise_o
);
  logic       sck_q, cs_q, active;
  logic [6:0] sh_q;
  logic [2:0] cnt_q;

  assign active      = ~cs_ni & hold_ni;
  assign sck_rise_o  = active & sck_i & ~sck_q;
  assign sck_fall_o  = active & ~sck_i & sck_q;
  assign cs_rise_o   = cs_ni & ~cs_q;
  assign byte_done_o = sck_rise_o & (cnt_q == 3'd7);
  assign byte_o      = {sh_q, si_i};
  assign bit_cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (sck_rise_o) begin
        sh_q  <= {sh_q[5:0], si_i};
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/spi_eep_prog.sv
module spi_eep_prog #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned PAGE_BYTES  = 4,
  parameter int unsigned PROG_CYCLES = 200,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W  = $clog2(PROG_CYCLES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     ld_i,
  input  logic [PAGE_W-1:0]        ld_idx_i,
  input  logic [7:0]               ld_data_i,
  input  logic                     start_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o,
  output logic                     done_o
);
  logic [7:0]               mem_q [DEPTH];
  logic [7:0]               pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    vld_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]         cnt_q;
  logic                     busy_q;

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;
  assign done_o    = busy_q & (cnt_q == '0);

  // page staging lanes
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pbuf_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (ld_i && ld_idx_i == PAGE_W'(g)) begin
        pbuf_q[g] <= ld_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      page_q <= page_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (done_o) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (vld_q[i]) mem_q[{page_q, PAGE_W'(i)}] <= pbuf_q[i];
    end
  end
endmodule

// File: rtl/spi_eep_ctrl.sv
module spi_eep_ctrl
  import spi_eep_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 4,
  parameter int unsigned PROG_CYCLES = 200,
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic so_o,
  output logic so_en_o
);
  logic              sck_rise, sck_fall, byte_done, cs_rise;
  logic [7:0]        rx_byte;
  logic [2:0]        bit_cnt;
  logic              busy, done;
  logic [7:0]        rd_data, status;
  logic [ADDR_W-1:0] rd_addr, addr_q, addr_nxt;
  eep_st_e           st_q;
  logic              a8_q, is_rd_q, wel, wr_any_q, so_q;
  logic [1:0]        bp;
  logic [7:0]        out_q;
  logic [PAGE_W-1:0] wptr_q;
  logic              clr, ld, start;

  spi_eep_frontend u_fe (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i, .hold_ni,
    .sck_rise_o (sck_rise), .sck_fall_o (sck_fall), .byte_done_o (byte_done),
    .byte_o (rx_byte), .bit_cnt_o (bit_cnt), .cs_rise_o (cs_rise)
  );

  assign addr_nxt = {a8_q, rx_byte};
  assign rd_addr  = (st_q == ST_ADDR) ? addr_nxt : addr_q + 1'b1;
  assign status   = {4'b0, bp, wel, busy};
  assign clr      = byte_done && st_q == ST_ADDR && !is_rd_q;
  assign ld       = byte_done && st_q == ST_WDATA;
  assign start    = cs_rise && st_q == ST_WDATA && bit_cnt == 3'd0 && wr_any_q && wp_ni && !busy;

  spi_eep_prog #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i, .rst_ni, .clr_i (clr), .ld_i (ld), .ld_idx_i (wptr_q), .ld_data_i (rx_byte),
    .start_i (start), .page_i (addr_q[ADDR_W-1:PAGE_W]), .rd_addr_i (rd_addr),
    .rd_data_o (rd_data), .busy_o (busy), .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_CMD;
      addr_q   <= '0;
      a8_q     <= 1'b0;
      is_rd_q  <= 1'b0;
      wel      <= 1'b0;
      bp       <= 2'b00;
      out_q    <= '0;
      wptr_q   <= '0;
      wr_any_q <= 1'b0;
    end else begin
      if (done) wel <= 1'b0;
      if (cs_ni) begin
        st_q <= ST_CMD;
      end else if (byte_done) begin
        unique case (st_q)
          ST_CMD: begin
            st_q <= ST_IGN;
            if (!busy || rx_byte == OP_RDSR) begin
              if (rx_byte == OP_WREN) wel <= 1'b1;
              else if (rx_byte == OP_WRDI) wel <= 1'b0;
              else if (rx_byte == OP_RDSR) begin
                out_q <= status;
                st_q  <= ST_RDSR;
              end else if (rx_byte == OP_WRSR) begin
                if (wel && wp_ni) st_q <= ST_SRDATA;
              end else if ((rx_byte & OP_A8_MASK) == OP_READ) begin
                a8_q    <= rx_byte[3];
                is_rd_q <= 1'b1;
                st_q    <= ST_ADDR;
              end else if ((rx_byte & OP_A8_MASK) == OP_WRITE && wel && wp_ni) begin
                a8_q    <= rx_byte[3];
                is_rd_q <= 1'b0;
                st_q    <= ST_ADDR;
              end
            end
          end
          ST_ADDR: begin
            addr_q <= addr_nxt;
            if (is_rd_q) begin
              out_q <= rd_data;
              st_q  <= ST_RDATA;
            end else if (region_locked(addr_nxt, bp)) begin
              st_q <= ST_IGN;
            end else begin
              wptr_q   <= addr_nxt[PAGE_W-1:0];
              wr_any_q <= 1'b0;
              st_q     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            addr_q <= rd_addr;
            out_q  <= rd_data;
          end
          ST_RDSR: out_q <= status;
          ST_WDATA: begin
            wptr_q   <= wptr_q + 1'b1;
            wr_any_q <= 1'b1;
          end
          ST_SRDATA: begin
            if (wp_ni) begin
              bp  <= rx_byte[3:2];
              wel <= 1'b0;
            end
            st_q <= ST_IGN;
          end
          default: st_q <= ST_IGN;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) so_q <= 1'b0;
    else if (cs_ni) so_q <= 1'b0;
    else if (sck_fall && (st_q == ST_RDATA || st_q == ST_RDSR)) so_q <= out_q[3'd7 - bit_cnt];
  end

  assign so_o    = so_q;
  assign so_en_o = ~cs_ni & hold_ni;
endmodule

// File: rtl/spi_eep_chk.sv
module spi_eep_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       wp_ni,
  input logic       so_o,
  input logic       busy_i,
  input logic       wel_i,
  input logic [1:0] bp_i
);
  assert_so_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !so_o);
  assert_start_on_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cs_ni));
  assert_wel_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !wel_i);
  assert_bp_frozen_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(bp_i));
  assert_no_prog_wp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && !busy_i) |=> !busy_i);
  assert_bp_frozen_wp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |=> $stable(bp_i));
endmodule

bind spi_eep_ctrl spi_eep_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .cs_ni (cs_ni), .wp_ni (wp_ni), .so_o (so_o),
  .busy_i (busy), .wel_i (wel), .bp_i (bp)
);

// File: tb/spi_eep_ctrl_tb_top.sv
module spi_eep_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_en;
  int   nchk = 0, nfail = 0;
  bit   finished = 1'b0;
  logic [7:0] ref_mem [512];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #4 clk = ~clk;

  spi_eep_ctrl dut_i (
    .clk_i (clk), .rst_ni (rst_n), .sck_i (sck), .cs_ni (cs_n), .si_i (si),
    .hold_ni (hold_n), .wp_ni (wp_n), .so_o (so), .so_en_o (so_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit hold_mid, input int nbits);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      si = tx[i];
      repeat (3) @(negedge clk);
      if (hold_mid && i == 3) begin
        hold_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 so_en during hold", so_en, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; repeat (2) @(negedge clk);
          sck = 1'b0; repeat (2) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
      end
      rx[i] = so;
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    cs_begin(); xfer(op, d, 0, 8); cs_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_begin(); xfer(8'h05, d, 0, 8); xfer(8'h00, s, 0, 8); cs_end();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_begin(); xfer(8'h01, d, 0, 8); xfer(v, d, 0, 8); cs_end();
  endtask

  task automatic rd(input int a, input int n, input int hold_at);
    logic [7:0] d;
    cs_begin();
    xfer({4'b0, a[8], 3'b011}, d, 0, 8);
    xfer(a[7:0], d, 0, 8);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k], k == hold_at, 8);
    cs_end();
  endtask

  task automatic wr(input int a, input int n);
    logic [7:0] d;
    cs_begin();
    xfer({4'b0, a[8], 3'b010}, d, 0, 8);
    xfer(a[7:0], d, 0, 8);
    for (int k = 0; k < n; k++) xfer(wbuf[k], d, 0, 8);
    cs_end();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 50; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  function automatic void model_write(input int a, input int n);
    for (int k = 0; k < n; k++) ref_mem[{a[8:2], 2'(a[1:0] + k)}] = wbuf[k];
  endfunction

  task automatic check_read(input string tag, input int a, input int n);
    rd(a, n, -1);
    for (int k = 0; k < n; k++) chk(tag, rbuf[k], ref_mem[(a + k) % 512]);
  endtask

  initial begin
    repeat (5000 * 40) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int unsigned seed;
    seed = $urandom(32'd2718);
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 so_en idle", so_en, 0);
    rdsr(s); chk("R1 status", s, 8'h00);
    check_read("R1 array zero", 0, 3);

    // R3 latch control
    op1(8'h06); rdsr(s); chk("R3 wren", s, 8'h02);
    op1(8'h04); rdsr(s); chk("R3 wrdi", s, 8'h00);

    // R5 page wrap with six bytes at 0x0A2
    for (int k = 0; k < 6; k++) wbuf[k] = 8'h30 + 8'(k);
    op1(8'h06); wr(32'h0A2, 6);
    rdsr(s); chk("R7 busy set", s, 8'h03);
    wait_ready(); rdsr(s); chk("R7 done wel clear", s, 8'h00);
    model_write(32'h0A2, 6);
    check_read("R5 page wrap", 32'h0A0, 4);
    chk("R5 overwrite slot", ref_mem[32'h0A2], 8'h34);

    // R4 + R12 sequential read with a hold inside byte 1
    rd(32'h0A0, 4, 1);
    for (int k = 0; k < 4; k++) chk("R12 hold read", rbuf[k], ref_mem[32'h0A0 + k]);

    // random page writes and sequential reads
    for (int it = 0; it < 20; it++) begin
      int a, n;
      a = $urandom_range(0, 511);
      n = $urandom_range(1, 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      op1(8'h06); wr(a, n);
      rdsr(s); chk("R7 busy", s, 8'h03);
      wait_ready();
      model_write(a, n);
      check_read("R5 random page", a & 32'h1FC, 4);
      check_read("R4 random seq", $urandom_range(0, 511), 5);
    end

    // R4 wrap at top of array
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    op1(8'h06); wr(32'h1FF, 1); wait_ready(); model_write(32'h1FF, 1);
    op1(8'h06); wbuf[0] = 8'hE2; wr(32'h000, 1); wait_ready(); model_write(32'h000, 1);
    check_read("R4 wrap 1FF", 32'h1FE, 4);

    // R8 commands ignored while busy
    wbuf[0] = 8'hA5;
    op1(8'h06); wr(32'h020, 1);
    wrsr(8'h0C);
    rd(32'h020, 1, -1); chk("R8 read ignored", rbuf[0], 8'h00);
    wait_ready(); model_write(32'h020, 1);
    rdsr(s); chk("R8 wrsr ignored", s, 8'h00);
    check_read("R8 write landed", 32'h020, 1);

    // R6 mid-byte abort
    op1(8'h06);
    cs_begin();
    xfer(8'h02, d, 0, 8); xfer(8'h40, d, 0, 8); xfer(8'h11, d, 0, 8); xfer(8'h22, d, 0, 4);
    cs_end();
    rdsr(s); chk("R6 abort no busy", s, 8'h02);
    check_read("R6 abort array", 32'h040, 2);
    op1(8'h04);

    // R6 opcode+address only, no data byte
    op1(8'h06);
    cs_begin(); xfer(8'h02, d, 0, 8); xfer(8'h44, d, 0, 8); cs_end();
    rdsr(s); chk("R6 no data no busy", s, 8'h02);
    op1(8'h04);

    // R9 write without latch
    wbuf[0] = 8'h77; wr(32'h050, 1);
    rdsr(s); chk("R9 no wel", s, 8'h00);
    check_read("R9 array", 32'h050, 1);
    wrsr(8'h0C); rdsr(s); chk("R9 wrsr no wel", s, 8'h00);

    // R11 write-protect pin
    op1(8'h06); wp_n = 1'b0;
    wbuf[0] = 8'h66; wr(32'h060, 1);
    rdsr(s); chk("R11 wp write", s, 8'h02);
    check_read("R11 wp array", 32'h060, 1);
    wrsr(8'h0C); rdsr(s); chk("R11 wp wrsr", s, 8'h02);
    wp_n = 1'b1; op1(8'h04);

    // R13 + R10 region codes
    op1(8'h06); wrsr(8'h04); rdsr(s); chk("R13 bp01 wel clr", s, 8'h04);
    op1(8'h06); wbuf[0] = 8'h5A; wr(32'h190, 1);
    rdsr(s); chk("R10 bp01 top blocked", s, 8'h06);
    check_read("R10 bp01 array", 32'h190, 1);
    wr(32'h110, 1); rdsr(s); chk("R10 bp01 low ok", s, 8'h07);
    wait_ready(); model_write(32'h110, 1);
    check_read("R10 bp01 written", 32'h110, 1);
    op1(8'h06); wrsr(8'h08);
    op1(8'h06); wr(32'h100, 1); rdsr(s); chk("R10 bp10 blocked", s, 8'h0A);
    op1(8'h04);
    op1(8'h06); wrsr(8'h0C);
    op1(8'h06); wr(32'h000, 1); rdsr(s); chk("R10 bp11 blocked", s, 8'h0E);
    check_read("R10 bp11 array", 32'h000, 1);
    wrsr(8'h00); rdsr(s); chk("R13 bp clear", s, 8'h00);

    chk("R2 so_en cs high", so_en, 0);
    chk("R2 so low cs high", so, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule